// File: doc/BRIEF.md
# Port Pin Configuration and Event Flag Controller

This block manages a port of general-purpose pins. Each pin owns a control word. The low half of that word sets up the pad: pull enable, pull direction, open-drain, input filter, a mux mode and a lock bit. The high half selects which event on the pin is watched, and it shows the pin's event flag. Software reaches every word over a simple single-cycle register bus. One extra address holds the flags of all pins in one word.

Pin inputs pass through two synchronizing flops, and then through a history flop that supports edge detection. An event is any of these: a rising edge, a falling edge, either edge, or a held low or high level. When an event is seen, the pin's flag is latched. Depending on the chosen code, that flag either feeds the shared interrupt line or appears as a DMA request for that pin. A DMA-completion strobe clears a DMA flag. Interrupt flags stay set until software writes a one to them. A held level sets its flag again in the same cycle that the flag is cleared.

Top module: `pinctl_port`

## Requirements
- R1: After reset every control word and the flag word read 0, and `irq_o`, `dma_req_o` and all pad outputs are 0.
- R2: An edge on `pin_i[i]` sets flag i at the third rising clock edge after the change. Code 9 (or 1) detects rising edges, code 10 (or 2) falling edges, and code 11 (or 3) both.
- R3: Code 8 sets the flag while the synchronized pin is 0, and code 12 sets it while the pin is 1. If software clears the flag while the level is still present, the flag stays 1.
- R4: Address NPINS reads flag i on bit i. Writing it clears every flag whose bit holds 1 and leaves the others alone. Writing 1 to bit 24 of control word i also clears flag i.
- R5: Codes 1, 2 and 3 are DMA modes. In these modes `dma_req_o[i]` equals flag i, and a 1 on `dma_done_i[i]` clears the flag at the next edge. In any other mode `dma_done_i[i]` has no effect.
- R6: `irq_o` is 1 exactly when some pin in modes 8 to 12 has its flag set. Flags of pins in DMA mode never raise `irq_o`.
- R7: Bit 15 of a control word is a lock. Once it is 1, writes leave bits 15:0 of that word and its pad outputs unchanged until reset. The event code in bits 19:16 stays writable. A write to a locked word completes normally.
- R8: Bits 6:4 hold the mux mode. In modes 0 (disabled) and 1 (analog), `pu_o`, `pd_o`, `od_o`, `filt_o` and `ibe_o` are forced to 0. In modes 2 to 7 they follow the word: `pu_o` is bit0&bit1, `pd_o` is bit0&!bit1, `od_o` is bit2, `filt_o` is bit3, and `ibe_o` is 1.
- R9: Event codes 0, 4 to 7 and 13 to 15 detect nothing.
- R10: A control word reads back as {flag at bit 24, code at bits 19:16, lock at bit 15, bits 6:0 as written}, with all other bits 0. An address above NPINS reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| bus_addr_i | input | $clog2(NPINS+1) | Register address: 0..NPINS-1 are control words, NPINS is the flag word |
| bus_wr_i | input | 1 | Write strobe |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for `bus_addr_i` (combinational) |
| pin_i | input | NPINS | Asynchronous pin levels |
| dma_done_i | input | NPINS | Per-pin DMA completion strobe |
| dma_req_o | output | NPINS | Per-pin DMA request |
| irq_o | output | 1 | Combined interrupt |
| pu_o | output | NPINS | Pull-up enable |
| pd_o | output | NPINS | Pull-down enable |
| od_o | output | NPINS | Open-drain enable |
| filt_o | output | NPINS | Input filter enable |
| ibe_o | output | NPINS | Input buffer enable |
| mux_o | output | 3*NPINS | Mux mode per pin, pin i at bits 3i+2:3i |

## Verification
The hardest situation to reach is a flag being cleared in the same cycle that a new event sets it. This happens with a level-mode pin held active while software writes the clear, and with a DMA completion strobe that lands on a pin whose edge arrives in the same cycle. The bench holds level pins steady while it issues the clears. A randomized phase then mixes pin toggles, completion strobes, clear writes and code changes across the upper pins. A behavioural model tracks the three-cycle delay from pin to flag and is compared on every clock. Locking is reached by writing the lock bit and then rewriting the same word, and a reset in the middle of the run shows that the lock is released.

// File: rtl/pinctl_pkg.sv
package pinctl_pkg;

    localparam int DET_W     = 4;
    localparam int MUX_W     = 3;
    localparam int DET_LSB   = 16;
    localparam int FLAG_BIT  = 24;
    localparam int LOCK_BIT  = 15;
    localparam int MUX_LSB   = 4;
    localparam int MUX_DIG_MIN = 2;

    typedef struct packed {
        logic             lock;
        logic [MUX_W-1:0] mux;
        logic             filt;
        logic             od;
        logic             pull_up;
        logic             pull_en;
    } pad_cfg_t;

    function automatic logic det_is_dma(input logic [DET_W-1:0] d);
        return (d == 4'd1) || (d == 4'd2) || (d == 4'd3);
    endfunction

    function automatic logic det_is_irq(input logic [DET_W-1:0] d);
        return (d >= 4'd8) && (d <= 4'd12);
    endfunction

    function automatic logic det_hit(input logic [DET_W-1:0] d,
                                     input logic lvl, input logic prev);
        logic r;
        case (d)
            4'd1, 4'd9:  r = lvl & ~prev;
            4'd2, 4'd10: r = ~lvl & prev;
            4'd3, 4'd11: r = lvl ^ prev;
            4'd8:        r = ~lvl;
            4'd12:       r = lvl;
            default:     r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pinctl_sync.sv
module pinctl_sync #(
    parameter int NPINS = 32
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [NPINS-1:0] pin_i,
    output logic [NPINS-1:0] lvl_o,
    output logic [NPINS-1:0] prev_o
);
    typedef struct packed {
        logic [NPINS-1:0] s0;
        logic [NPINS-1:0] s1;
        logic [NPINS-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s0   = pin_i;
        st_d.s1   = st_q.s0;
        st_d.prev = st_q.s1;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign lvl_o  = st_q.s1;
    assign prev_o = st_q.prev;
endmodule

// File: rtl/pinctl_pin.sv
module pinctl_pin
    import pinctl_pkg::*;
(
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             wr_i,
    input  logic [31:0]      wdata_i,
    input  logic             clr_i,
    input  logic             lvl_i,
    input  logic             prev_i,
    input  logic             dma_done_i,
    output logic [31:0]      rd_word_o,
    output logic             flag_o,
    output logic             lock_o,
    output logic             dma_req_o,
    output logic             irq_req_o,
    output logic             pu_o,
    output logic             pd_o,
    output logic             od_o,
    output logic             filt_o,
    output logic             ibe_o,
    output logic [MUX_W-1:0] mux_o
);
    typedef struct packed {
        pad_cfg_t         cfg;
        logic [DET_W-1:0] det;
        logic             flag;
    } pin_t;

    pin_t st_d, st_q;
    logic hit, clr, dig;

    always_comb begin
        st_d = st_q;
        hit  = det_hit(st_q.det, lvl_i, prev_i);
        clr  = clr_i | (wr_i & wdata_i[FLAG_BIT])
             | (det_is_dma(st_q.det) & dma_done_i);
        // a fresh event overrides a clear in the same cycle
        st_d.flag = (st_q.flag & ~clr) | hit;
        if (wr_i) begin
            st_d.det = wdata_i[DET_LSB +: DET_W];
            if (!st_q.cfg.lock) begin
                st_d.cfg.lock    = wdata_i[LOCK_BIT];
                st_d.cfg.mux     = wdata_i[MUX_LSB +: MUX_W];
                st_d.cfg.filt    = wdata_i[3];
                st_d.cfg.od      = wdata_i[2];
                st_d.cfg.pull_up = wdata_i[1];
                st_d.cfg.pull_en = wdata_i[0];
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        rd_word_o                     = '0;
        rd_word_o[FLAG_BIT]           = st_q.flag;
        rd_word_o[DET_LSB +: DET_W]   = st_q.det;
        rd_word_o[LOCK_BIT]           = st_q.cfg.lock;
        rd_word_o[MUX_LSB +: MUX_W]   = st_q.cfg.mux;
        rd_word_o[3]                  = st_q.cfg.filt;
        rd_word_o[2]                  = st_q.cfg.od;
        rd_word_o[1]                  = st_q.cfg.pull_up;
        rd_word_o[0]                  = st_q.cfg.pull_en;
    end

    assign dig       = (st_q.cfg.mux >= MUX_W'(MUX_DIG_MIN));
    assign flag_o    = st_q.flag;
    assign lock_o    = st_q.cfg.lock;
    assign dma_req_o = st_q.flag & det_is_dma(st_q.det);
    assign irq_req_o = st_q.flag & det_is_irq(st_q.det);
    assign pu_o      = dig & st_q.cfg.pull_en & st_q.cfg.pull_up;
    assign pd_o      = dig & st_q.cfg.pull_en & ~st_q.cfg.pull_up;
    assign od_o      = dig & st_q.cfg.od;
    assign filt_o    = dig & st_q.cfg.filt;
    assign ibe_o     = dig;
    assign mux_o     = st_q.cfg.mux;
endmodule

// File: rtl/pinctl_port.sv
module pinctl_port
    import pinctl_pkg::*;
#(
    parameter int NPINS = 32,
    localparam int AW   = $clog2(NPINS + 1)
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [AW-1:0]      bus_addr_i,
    input  logic               bus_wr_i,
    input  logic [31:0]        bus_wdata_i,
    output logic [31:0]        bus_rdata_o,
    input  logic [NPINS-1:0]   pin_i,
    input  logic [NPINS-1:0]   dma_done_i,
    output logic [NPINS-1:0]   dma_req_o,
    output logic               irq_o,
    output logic [NPINS-1:0]   pu_o,
    output logic [NPINS-1:0]   pd_o,
    output logic [NPINS-1:0]   od_o,
    output logic [NPINS-1:0]   filt_o,
    output logic [NPINS-1:0]   ibe_o,
    output logic [MUX_W*NPINS-1:0] mux_o
);
    logic [NPINS-1:0] lvl, prev, flag_vec, lock_vec, irq_vec;
    logic [31:0]      rd_word [NPINS];
    logic             stat_wr;

    assign stat_wr = bus_wr_i && (bus_addr_i == AW'(NPINS));

    pinctl_sync #(.NPINS(NPINS)) sync_i (
        .clk_i (clk_i), .rst_ni(rst_ni), .pin_i(pin_i),
        .lvl_o (lvl),   .prev_o(prev)
    );

    for (genvar g = 0; g < NPINS; g++) begin : g_pin
        pinctl_pin pin_i_u (
            .clk_i     (clk_i),
            .rst_ni    (rst_ni),
            .wr_i      (bus_wr_i && (bus_addr_i == AW'(g))),
            .wdata_i   (bus_wdata_i),
            .clr_i     (stat_wr && bus_wdata_i[g]),
            .lvl_i     (lvl[g]),
            .prev_i    (prev[g]),
            .dma_done_i(dma_done_i[g]),
            .rd_word_o (rd_word[g]),
            .flag_o    (flag_vec[g]),
            .lock_o    (lock_vec[g]),
            .dma_req_o (dma_req_o[g]),
            .irq_req_o (irq_vec[g]),
            .pu_o      (pu_o[g]),
            .pd_o      (pd_o[g]),
            .od_o      (od_o[g]),
            .filt_o    (filt_o[g]),
            .ibe_o     (ibe_o[g]),
            .mux_o     (mux_o[g*MUX_W +: MUX_W])
        );
    end

    assign irq_o = |irq_vec;

    always_comb begin
        bus_rdata_o = '0;
        for (int i = 0; i < NPINS; i++) begin
            if (bus_addr_i == AW'(i)) bus_rdata_o = rd_word[i];
        end
        if (bus_addr_i == AW'(NPINS)) begin
            for (int i = 0; i < NPINS; i++) bus_rdata_o[i] = flag_vec[i];
        end
    end
endmodule

// File: rtl/pinctl_port_chk.sv
module pinctl_port_chk
    import pinctl_pkg::*;
#(
    parameter int NPINS = 32
) (
    input logic                   clk_i,
    input logic                   rst_ni,
    input logic                   irq_o,
    input logic [NPINS-1:0]       dma_req_o,
    input logic [NPINS-1:0]       pu_o,
    input logic [NPINS-1:0]       pd_o,
    input logic [NPINS-1:0]       od_o,
    input logic [NPINS-1:0]       filt_o,
    input logic [NPINS-1:0]       ibe_o,
    input logic [MUX_W*NPINS-1:0] mux_o,
    input logic [NPINS-1:0]       flag_i,
    input logic [NPINS-1:0]       lock_i
);
    assert_irq_source_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        irq_o |-> (flag_i != '0));

    for (genvar i = 0; i < NPINS; i++) begin : g_chk
        assert_mux_off_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            (mux_o[i*MUX_W +: MUX_W] < MUX_W'(MUX_DIG_MIN))
            |-> !(pu_o[i] || pd_o[i] || od_o[i] || filt_o[i] || ibe_o[i]));

        assert_pull_excl_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
            !(pu_o[i] && pd_o[i]));

        assert_lock_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(lock_i[i]) |-> lock_i[i]);

        assert_lock_frozen_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(lock_i[i]) |-> ($stable(pu_o[i]) && $stable(pd_o[i]) && $stable(od_o[i])
                && $stable(filt_o[i]) && $stable(mux_o[i*MUX_W +: MUX_W])));

        assert_dma_flag_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
            dma_req_o[i] |-> flag_i[i]);
    end
endmodule

bind pinctl_port pinctl_port_chk #(.NPINS(NPINS)) chk_i (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .irq_o    (irq_o),
    .dma_req_o(dma_req_o),
    .pu_o     (pu_o),
    .pd_o     (pd_o),
    .od_o     (od_o),
    .filt_o   (filt_o),
    .ibe_o    (ibe_o),
    .mux_o    (mux_o),
    .flag_i   (flag_vec),
    .lock_i   (lock_vec)
);

// File: tb/pinctl_port_tb_top.sv
module pinctl_port_tb_top;
    localparam int N  = 32;
    localparam int AW = $clog2(N + 1);

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [AW-1:0] addr = AW'(N);
    logic          wr = 1'b0;
    logic [31:0]   wdata = '0;
    logic [31:0]   rdata;
    logic [N-1:0]  pins = '0;
    logic [N-1:0]  done = '0;
    logic [N-1:0]  dma_req, pu, pd, od, filt, ibe;
    logic          irq;
    logic [3*N-1:0] mux;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    pinctl_port #(.NPINS(N)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr),
        .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pins),
        .dma_done_i(done), .dma_req_o(dma_req), .irq_o(irq),
        .pu_o(pu), .pd_o(pd), .od_o(od), .filt_o(filt), .ibe_o(ibe), .mux_o(mux)
    );

    // ---------------- behavioural reference model ----------------
    bit [N-1:0] m_s0, m_s1, m_prev, m_flag;
    bit [3:0]   m_det [N];
    bit [15:0]  m_low [N];

    function automatic bit ev(bit [3:0] d, bit l, bit p);
        case (d)
            1, 9:  return l && !p;
            2, 10: return !l && p;
            3, 11: return l != p;
            8:     return !l;
            12:    return l;
            default: return 0;
        endcase
    endfunction

    function automatic bit is_dma(bit [3:0] d);
        return d >= 1 && d <= 3;
    endfunction

    function automatic bit is_irq(bit [3:0] d);
        return d >= 8 && d <= 12;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_s0 = '0; m_s1 = '0; m_prev = '0; m_flag = '0;
            for (int i = 0; i < N; i++) begin m_det[i] = 0; m_low[i] = 0; end
        end else begin
            bit [N-1:0] nf;
            for (int i = 0; i < N; i++) begin
                bit c;
                c = (wr && addr == AW'(N) && wdata[i])
                  || (wr && addr == AW'(i) && wdata[24])
                  || (is_dma(m_det[i]) && done[i]);
                nf[i] = (m_flag[i] && !c) || ev(m_det[i], m_s1[i], m_prev[i]);
            end
            m_flag = nf;
            if (wr && addr < AW'(N)) begin
                m_det[addr] = wdata[19:16];
                if (!m_low[addr][15]) m_low[addr] = wdata[15:0] & 16'h807F;
            end
            m_prev = m_s1; m_s1 = m_s0; m_s0 = pins;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !finished) begin
            logic [31:0] er;
            logic [N-1:0] eirq, edma, epu, epd, eod, ef, eib;
            logic [3*N-1:0] emux;
            er = '0;
            if (addr < AW'(N))
                er = {7'b0, m_flag[addr], 4'b0, m_det[addr], m_low[addr]};
            else if (addr == AW'(N))
                er = m_flag;
            for (int i = 0; i < N; i++) begin
                bit dg;
                dg = m_low[i][6:4] >= 2;
                eirq[i] = m_flag[i] && is_irq(m_det[i]);
                edma[i] = m_flag[i] && is_dma(m_det[i]);
                epu[i]  = dg && m_low[i][0] && m_low[i][1];
                epd[i]  = dg && m_low[i][0] && !m_low[i][1];
                eod[i]  = dg && m_low[i][2];
                ef[i]   = dg && m_low[i][3];
                eib[i]  = dg;
                emux[i*3 +: 3] = m_low[i][6:4];
            end
            chk("R10 readback", rdata, er);
            chk("R6 irq", 32'(irq), 32'(|eirq));
            chk("R5 dma_req", dma_req, edma);
            chk("R8 pu", pu, epu);
            chk("R8 pd", pd, epd);
            chk("R8 od", od, eod);
            chk("R8 filt", filt, ef);
            chk("R8 ibe", ibe, eib);
            chk("R7 mux lo", mux[31:0], emux[31:0]);
            chk("R7 mux mid", mux[63:32], emux[63:32]);
            chk("R7 mux hi", mux[95:64], emux[95:64]);
        end
    end

    // ---------------- stimulus ----------------
    task automatic step(int n);
        for (int k = 0; k < n; k++) begin @(posedge clk); #1; end
    endtask

    task automatic wreg(int a, logic [31:0] d);
        @(posedge clk); #1;
        addr = AW'(a); wdata = d; wr = 1'b1;
        @(posedge clk); #1;
        wr = 1'b0;
    endtask

    task automatic rchk(string tag, int a, logic [31:0] exp);
        addr = AW'(a);
        @(negedge clk);
        chk(tag, rdata, exp);
    endtask

    task automatic do_reset();
        rst_n = 1'b0; step(4); rst_n = 1'b1; step(1);
    endtask

    initial begin
        step(2);
        do_reset();
        // R1: reset state
        rchk("R1 ctrl0", 0, 32'h0);
        rchk("R1 flags", N, 32'h0);
        chk("R1 irq", 32'(irq), 0);
        chk("R1 ibe", ibe, 0);

        // R2 / R9 edge modes and a reserved code
        wreg(0, 32'h0009_0000);
        wreg(1, 32'h000A_0000);
        wreg(2, 32'h000B_0000);
        wreg(5, 32'h0001_0000);
        wreg(8, 32'h0005_0000);
        @(posedge clk); #1; pins = 32'h0000_0125;
        step(2);
        rchk("R2 not before third edge", N, 32'h0);
        step(1);
        rchk("R2 rising/both/dma edges; R9 code 5 silent", N, 32'h0000_0025);
        chk("R6 irq from irq-mode pins", 32'(irq), 1);
        chk("R5 dma_req pin5", dma_req, 32'h20);

        // R2 falling edge on pin1
        pins[1] = 1'b1; step(4); pins[1] = 1'b0; step(4);
        rchk("R2 falling pin1", N, 32'h0000_0027);

        // R4 clears
        wreg(N, 32'h0000_0003);
        rchk("R4 w1c status", N, 32'h0000_0024);
        wreg(2, 32'h010B_0000);
        rchk("R4 w1c via ctrl bit24", N, 32'h0000_0020);
        chk("R6 dma flag alone no irq", 32'(irq), 0);

        // R5 completion strobe
        @(posedge clk); #1; done[5] = 1'b1;
        @(posedge clk); #1; done[5] = 1'b0;
        rchk("R5 dma done clears", N, 32'h0);
        pins[0] = 1'b0; step(4); pins[0] = 1'b1; step(4);
        @(posedge clk); #1; done[0] = 1'b1;
        @(posedge clk); #1; done[0] = 1'b0;
        rchk("R5 done ignored in irq mode", N, 32'h0000_0001);
        wreg(N, 32'h1);

        // R3 level modes
        wreg(3, 32'h0008_0000);
        step(2);
        wreg(N, 32'h0000_0008);
        rchk("R3 low level re-sets", N, 32'h0000_0008);
        pins[3] = 1'b1; step(4);
        wreg(N, 32'h0000_0008);
        rchk("R3 cleared once released", N, 32'h0);
        wreg(4, 32'h000C_0000);
        pins[4] = 1'b1; step(4);
        rchk("R3 high level", N, 32'h0000_0010);
        pins[4] = 1'b0; step(3);
        wreg(N, 32'h10);

        // R8 pad forcing
        wreg(10, 32'h0000_002F);
        addr = AW'(N); @(negedge clk);
        chk("R8 digital pads", {pu[10], pd[10], od[10], filt[10], ibe[10]}, 32'b10111);
        wreg(11, 32'h0000_001F);
        @(negedge clk);
        chk("R8 analog forced off", {pu[11], pd[11], od[11], filt[11], ibe[11]}, 0);
        wreg(12, 32'h0000_000D);
        @(negedge clk);
        chk("R8 disabled forced off", {pu[12], pd[12], od[12], filt[12], ibe[12]}, 0);

        // R7 lock
        wreg(13, 32'h0000_8023);
        wreg(13, 32'h0009_0041);
        rchk("R7 locked lower kept, code taken", 13, 32'h0009_8023);
        pins[13] = 1'b1; step(4);
        rchk("R7 locked pin still detects", 13, 32'h0109_8023);

        // R10 readback mask, R9 code 15
        wreg(14, 32'hFFFF_FFFF);
        rchk("R10 mask", 14, 32'h000F_807F);
        pins[14] = 1'b1; step(4); pins[14] = 1'b0; step(4);
        rchk("R9 code 15 silent", 14, 32'h000F_807F);
        rchk("R10 out of range", N + 1, 32'h0);

        // randomized phase on upper pins
        for (int k = 0; k < 1500; k++) begin
            @(posedge clk); #1;
            pins[31:16] = 16'($urandom);
            done = '0;
            done[31:16] = 16'($urandom) & 16'($urandom);
            wr = 1'b0;
            case ($urandom_range(0, 5))
                0: begin
                    bit [3:0] codes [10] = '{0, 1, 2, 3, 8, 9, 10, 11, 12, 6};
                    addr = AW'($urandom_range(16, 31)); wr = 1'b1;
                    wdata = {7'b0, 1'($urandom), 4'b0, codes[$urandom_range(0, 9)],
                             1'($urandom_range(0, 7) == 0), 15'($urandom)};
                end
                1: begin addr = AW'(N); wr = 1'b1; wdata = $urandom; end
                default: addr = AW'($urandom_range(0, N + 1));
            endcase
        end
        @(posedge clk); #1; wr = 1'b0; done = '0; pins = '0;

        // reset releases lock (R7) and clears all (R1)
        do_reset();
        rchk("R1 after second reset", 13, 32'h0);
        wreg(13, 32'h0000_0021);
        rchk("R7 lock gone after reset", 13, 32'h0000_0021);

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            total++; bad++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule